// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit microcontroller core. Each accepted operation takes two byte operands (the decoder supplies either a register value or an immediate on the second operand), the carry held in the block's own status register, and an operation code. It produces a byte result, a write-back enable for the register file and updated condition flags. Register storage, instruction fetch and memory access are not part of it.

The status register keeps carry, zero, negative, overflow, sign, half-carry, a transfer bit and an interrupt-enable bit. Two rules let software chain operations across bytes. Increment and decrement leave carry alone. Subtract and compare with carry can only clear the zero flag, so a multi-byte compare ends with Z set only when every byte matched.

A dedicated operation sets or clears any single status bit. An unsigned 8x8 multiply runs over two clocks and returns a 16-bit product split over two output bytes.

Top module: `flag_alu`

## Requirements
- R1: Status bit positions are carry 0, zero 1, negative 2, overflow 3, sign 4, half-carry 5, transfer 6, interrupt-enable 7. Reset clears status, result, resultHi, writeEn and busy. After any flag-updating ALU operation, sign equals negative XOR overflow, and negative is bit 7 of the result.
- R2: Increment (code 10) and decrement (code 11) update Z, N, V and S but leave C and H unchanged. V is set when increment yields 0x80 or decrement yields 0x7F.
- R3: Subtract-with-carry (code 4) and compare-with-carry (code 6) never set Z. They clear Z when the byte result is non-zero and otherwise keep the previous Z.
- R4: Compare (code 5) and compare-with-carry (code 6) update flags and the result output but leave writeEn low.
- R5: Add (code 1) and add-with-carry (code 2, adds the stored C) set C from the carry out of bit 7, H from the carry out of bit 3, and V on signed overflow. Adding a value to itself gives a shift left, or a rotate left through carry with code 2.
- R6: Subtract (code 3) and the subtract-type codes 4, 5, 6 and 13 set C to the borrow out of bit 7, H to the borrow out of bit 3, and V on signed overflow.
- R7: AND (code 7), OR (code 8) and XOR (code 9) clear V and leave C and H unchanged.
- R8: One's complement (code 12) sets C and clears V. Negate (code 13) yields 0 minus opA, sets C when the result is non-zero, and sets V when it is 0x80. Nibble swap (code 14) exchanges the two halves of opA and changes no flag.
- R9: Arithmetic shift right (15) keeps bit 7, logical shift right (16) inserts 0, and rotate right (17) inserts the old C into bit 7. All three put opA bit 0 into C and set V to N XOR C. H is unchanged.
- R10: Flag write (code 18) sets status bit flagIdx to flagPol and leaves every other status bit, result and resultHi unchanged, with writeEn low.
- R11: Every single-byte operation issued with opValid high shows its result, writeEn and flags at the outputs one clock later. Code 0 and the unused codes 20 to 31 change nothing.
- R12: Multiply (code 19) raises busy for exactly the clock after issue. One clock later, result holds the low byte and resultHi the high byte of opA*opB, writeEn is high, C equals product bit 15 and Z is set for a zero product. No other flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation issued this cycle |
| opCode | input | 5 | Operation select (codes in the requirements) |
| opA | input | 8 | First operand (destination register value) |
| opB | input | 8 | Second operand (register or immediate) |
| flagIdx | input | 3 | Status bit selected by a flag write |
| flagPol | input | 1 | Value written by a flag write |
| result | output | 8 | Result byte, or product low byte |
| resultHi | output | 8 | Product high byte, zero after other loads |
| writeEn | output | 1 | Result should be written back |
| busy | output | 1 | Multiply in its first cycle |
| status | output | 8 | Status register |

## Verification
The embedded properties assume that the core never issues an operation while busy is high, meaning the clock that follows a multiply issue. One property states that assumption outright. The stimulus always leaves opValid low for that clock after each multiply, in both the directed and the random phases. The flag and write-back properties assume only that the operation code is stable within the cycle it is issued. The stimulus holds every input from one falling edge to the next.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int ALU_W  = 8;
  localparam int HALF_W = ALU_W / 2;
  localparam int PROD_W = 2 * ALU_W;
  localparam int STAT_W = 8;
  localparam int IDX_W  = $clog2(STAT_W);
  localparam int OP_W   = 5;

  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_V = 3;
  localparam int BIT_S = 4;
  localparam int BIT_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_ADC  = 5'd2,  OP_SUB  = 5'd3,
    OP_SBC  = 5'd4,  OP_CP   = 5'd5,  OP_CPC  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_INC  = 5'd10, OP_DEC  = 5'd11,
    OP_COM  = 5'd12, OP_NEG  = 5'd13, OP_SWAP = 5'd14, OP_ASR  = 5'd15,
    OP_LSR  = 5'd16, OP_ROR  = 5'd17, OP_FLAG = 5'd18, OP_MUL  = 5'd19
  } alu_op_e;

  typedef struct packed {
    logic aluFlags;
    logic flagWrite;
    logic loadResult;
    logic wrEn;
    logic mulCapture;
    logic mulFinish;
  } alu_strobe_t;
endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opValid,
  input  alu_op_e     opSel,
  output alu_strobe_t strobes,
  output logic        busy
);
  logic mulPending;

  always_comb begin
    strobes = '0;
    strobes.mulFinish = mulPending;
    if (mulPending) begin
      strobes.loadResult = 1'b1;
      strobes.wrEn       = 1'b1;
    end else if (opValid) begin
      case (opSel)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_XOR, OP_INC,
        OP_DEC, OP_COM, OP_NEG, OP_ASR, OP_LSR, OP_ROR: begin
          strobes.aluFlags   = 1'b1;
          strobes.loadResult = 1'b1;
          strobes.wrEn       = 1'b1;
        end
        OP_SWAP: begin
          strobes.loadResult = 1'b1;
          strobes.wrEn       = 1'b1;
        end
        OP_CP, OP_CPC: begin
          strobes.aluFlags   = 1'b1;
          strobes.loadResult = 1'b1;
        end
        OP_FLAG: strobes.flagWrite  = 1'b1;
        OP_MUL:  strobes.mulCapture = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mulPending <= 1'b0;
    else        mulPending <= strobes.mulCapture;
  end

  assign busy = mulPending;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy); // R12
  AST_NO_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !opValid); // R12
endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  alu_strobe_t       strobes,
  input  alu_op_e           opSel,
  input  logic [ALU_W-1:0]  opA,
  input  logic [ALU_W-1:0]  opB,
  input  logic [IDX_W-1:0]  flagIdx,
  input  logic              flagPol,
  output logic [ALU_W-1:0]  result,
  output logic [ALU_W-1:0]  resultHi,
  output logic              writeEn,
  output logic [STAT_W-1:0] status
);
  logic [ALU_W-1:0]  opX, opY, aluRes, mulA, mulB;
  logic [ALU_W:0]    sumW, diffW;
  logic [PROD_W-1:0] product;
  logic [STAT_W-1:0] aluStat, flagStat;
  logic cinBit, isSubLike, hAdd, hSub, vAdd, vSub;
  logic cNew, hNew, vNew, zSticky;

  assign isSubLike = (opSel == OP_NEG);
  assign opX = isSubLike ? '0 : opA;
  assign opY = (opSel == OP_INC || opSel == OP_DEC) ? ALU_W'(1) :
               (opSel == OP_NEG) ? opA : opB;
  assign cinBit = status[BIT_C] & (opSel == OP_ADC || opSel == OP_SBC || opSel == OP_CPC);

  assign sumW  = {1'b0, opX} + {1'b0, opY} + {{ALU_W{1'b0}}, cinBit};
  assign diffW = {1'b0, opX} - {1'b0, opY} - {{ALU_W{1'b0}}, cinBit};

  assign hAdd = (opX[HALF_W-1] & opY[HALF_W-1]) | (opY[HALF_W-1] & ~sumW[HALF_W-1]) |
                (~sumW[HALF_W-1] & opX[HALF_W-1]);
  assign hSub = (~opX[HALF_W-1] & opY[HALF_W-1]) | (opY[HALF_W-1] & diffW[HALF_W-1]) |
                (diffW[HALF_W-1] & ~opX[HALF_W-1]);
  assign vAdd = (opX[ALU_W-1] & opY[ALU_W-1] & ~sumW[ALU_W-1]) |
                (~opX[ALU_W-1] & ~opY[ALU_W-1] & sumW[ALU_W-1]);
  assign vSub = (opX[ALU_W-1] & ~opY[ALU_W-1] & ~diffW[ALU_W-1]) |
                (~opX[ALU_W-1] & opY[ALU_W-1] & diffW[ALU_W-1]);

  always_comb begin
    aluRes  = opA;
    cNew    = status[BIT_C];
    hNew    = status[BIT_H];
    vNew    = 1'b0;
    zSticky = 1'b0;
    case (opSel)
      OP_ADD, OP_ADC, OP_INC: begin
        aluRes = sumW[ALU_W-1:0];
        vNew   = vAdd;
        if (opSel != OP_INC) begin
          cNew = sumW[ALU_W];
          hNew = hAdd;
        end
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_DEC, OP_NEG: begin
        aluRes  = diffW[ALU_W-1:0];
        vNew    = vSub;
        zSticky = (opSel == OP_SBC || opSel == OP_CPC);
        if (opSel != OP_DEC) begin
          cNew = diffW[ALU_W];
          hNew = hSub;
        end
      end
      OP_AND:  aluRes = opA & opB;
      OP_OR:   aluRes = opA | opB;
      OP_XOR:  aluRes = opA ^ opB;
      OP_COM: begin
        aluRes = ~opA;
        cNew   = 1'b1;
      end
      OP_SWAP: aluRes = {opA[HALF_W-1:0], opA[ALU_W-1:HALF_W]};
      OP_ASR, OP_LSR, OP_ROR: begin
        aluRes[ALU_W-2:0] = opA[ALU_W-1:1];
        aluRes[ALU_W-1]   = (opSel == OP_ASR) ? opA[ALU_W-1] :
                            (opSel == OP_ROR) ? status[BIT_C] : 1'b0;
        cNew = opA[0];
        vNew = aluRes[ALU_W-1] ^ opA[0];
      end
      default: ;
    endcase
    aluStat        = status;
    aluStat[BIT_C] = cNew;
    aluStat[BIT_Z] = (aluRes == '0) & (~zSticky | status[BIT_Z]);
    aluStat[BIT_N] = aluRes[ALU_W-1];
    aluStat[BIT_V] = vNew;
    aluStat[BIT_S] = aluRes[ALU_W-1] ^ vNew;
    aluStat[BIT_H] = hNew;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_flagBit
    assign flagStat[i] = (flagIdx == IDX_W'(i)) ? flagPol : status[i];
  end

  assign product = mulA * mulB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      resultHi <= '0;
      writeEn  <= 1'b0;
      status   <= '0;
      mulA     <= '0;
      mulB     <= '0;
    end else begin
      writeEn <= strobes.wrEn;
      if (strobes.mulCapture) begin
        mulA <= opA;
        mulB <= opB;
      end
      if (strobes.mulFinish) begin
        result         <= product[ALU_W-1:0];
        resultHi       <= product[PROD_W-1:ALU_W];
        status[BIT_C]  <= product[PROD_W-1];
        status[BIT_Z]  <= (product == '0);
      end else begin
        if (strobes.loadResult) begin
          result   <= aluRes;
          resultHi <= '0;
        end
        if (strobes.aluFlags)  status <= aluStat;
        if (strobes.flagWrite) status <= flagStat;
      end
    end
  end

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (strobes.aluFlags && (opSel == OP_INC || opSel == OP_DEC)) |=> status[BIT_C] == $past(status[BIT_C])); // R2
  AST_STICKY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (strobes.aluFlags && (opSel == OP_SBC || opSel == OP_CPC) && !status[BIT_Z]) |=> !status[BIT_Z]); // R3
  AST_COMPARE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) (strobes.aluFlags && !strobes.wrEn) |=> !writeEn); // R4
  AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) strobes.flagWrite |=> $countones(status ^ $past(status)) <= 1); // R10
  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n) strobes.aluFlags |=> status[BIT_S] == (status[BIT_N] ^ status[BIT_V])); // R1
  AST_MUL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) strobes.mulFinish |=> status[BIT_Z] == (result == '0 && resultHi == '0)); // R12
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [ALU_W-1:0]  opA,
  input  logic [ALU_W-1:0]  opB,
  input  logic [IDX_W-1:0]  flagIdx,
  input  logic              flagPol,
  output logic [ALU_W-1:0]  result,
  output logic [ALU_W-1:0]  resultHi,
  output logic              writeEn,
  output logic              busy,
  output logic [STAT_W-1:0] status
);
  alu_op_e     opSel;
  alu_strobe_t strobes;

  assign opSel = alu_op_e'(opCode);

  flag_alu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .opValid (opValid),
    .opSel   (opSel),
    .strobes (strobes),
    .busy    (busy)
  );

  flag_alu_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .opSel    (opSel),
    .opA      (opA),
    .opB      (opB),
    .flagIdx  (flagIdx),
    .flagPol  (flagPol),
    .result   (result),
    .resultHi (resultHi),
    .writeEn  (writeEn),
    .status   (status)
  );
endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic [2:0] flagIdx = '0;
  logic       flagPol = 1'b0;
  logic [7:0] result, resultHi, status;
  logic       writeEn, busy;

  flag_alu u_flag_alu (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .flagIdx(flagIdx), .flagPol(flagPol),
    .result(result), .resultHi(resultHi), .writeEn(writeEn),
    .busy(busy), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit started = 0;
  string curTag = "R11";
  string mTag = "R1";

  logic [7:0]  mRes, mHi, mStat;
  logic        mWe, mBusy;
  logic [15:0] mProd;

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelOp();
    int a, b, aa, bb, cin, t, st, r;
    bit c, h, v, upd, wr, ld, sticky, n, z;
    a = opA; b = opB; r = 0;
    c = mStat[0]; h = mStat[5]; v = 0;
    upd = 1; wr = 1; ld = 1; sticky = 0;
    case (opCode)
      1, 2, 10: begin
        bb  = (opCode == 10) ? 1 : b;
        cin = (opCode == 2) ? int'(mStat[0]) : 0;
        t = a + bb + cin; r = t % 256;
        st = sgn(a) + sgn(bb) + cin;
        v = (st > 127 || st < -128);
        if (opCode != 10) begin
          c = (t > 255);
          h = ((a % 16) + (bb % 16) + cin) > 15;
        end
      end
      3, 4, 5, 6, 11, 13: begin
        aa  = (opCode == 13) ? 0 : a;
        bb  = (opCode == 11) ? 1 : (opCode == 13) ? a : b;
        cin = (opCode == 4 || opCode == 6) ? int'(mStat[0]) : 0;
        t = aa - bb - cin; r = (t + 512) % 256;
        st = sgn(aa) - sgn(bb) - cin;
        v = (st > 127 || st < -128);
        if (opCode != 11) begin
          c = (t < 0);
          h = ((aa % 16) - (bb % 16) - cin) < 0;
        end
        sticky = (opCode == 4 || opCode == 6);
        wr = !(opCode == 5 || opCode == 6);
      end
      7:  r = a & b;
      8:  r = a | b;
      9:  r = a ^ b;
      12: begin r = 255 - a; c = 1; end
      14: begin r = (a % 16) * 16 + a / 16; upd = 0; end
      15: begin r = a / 2 + (a & 128); c = a % 2; v = ((r / 128) % 2) ^ c; end
      16: begin r = a / 2; c = a % 2; v = c; end
      17: begin r = a / 2 + int'(mStat[0]) * 128; c = a % 2; v = ((r / 128) % 2) ^ c; end
      18: begin mStat[flagIdx] = flagPol; upd = 0; ld = 0; wr = 0; end
      19: begin mProd = 16'(a * b); mBusy = 1; upd = 0; ld = 0; wr = 0; end
      default: begin upd = 0; ld = 0; wr = 0; end
    endcase
    if (ld) begin mRes = 8'(r); mHi = 8'h00; end
    mWe = wr;
    if (upd) begin
      n = (r >= 128);
      z = (r == 0) && (!sticky || mStat[1]);
      mStat[0] = c; mStat[1] = z; mStat[2] = n;
      mStat[3] = v; mStat[4] = n ^ v; mStat[5] = h;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mRes = 0; mHi = 0; mStat = 0; mWe = 0; mBusy = 0; mProd = 0;
    end else begin
      mWe = 0;
      if (mBusy) begin
        mBusy = 0;
        mRes = mProd[7:0]; mHi = mProd[15:8]; mWe = 1;
        mStat[0] = mProd[15]; mStat[1] = (mProd == 0);
      end else if (opValid) begin
        mTag = curTag;
        modelOp();
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(mTag, "result", int'(result), int'(mRes));
      chk(mTag, "resultHi", int'(resultHi), int'(mHi));
      chk(mTag, "writeEn", int'(writeEn), int'(mWe));
      chk(mTag, "busy", int'(busy), int'(mBusy));
      chk(mTag, "status", int'(status), int'(mStat));
    end
  end

  task automatic issue(int op, int a, int b, int idx, int pol, string tag);
    @(negedge clk);
    opValid = 1'b1; opCode = 5'(op); opA = 8'(a); opB = 8'(b);
    flagIdx = 3'(idx); flagPol = pol[0]; curTag = tag;
    if (op == 19) begin
      @(negedge clk);
      opValid = 1'b0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      opValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset status", int'(status), 0);
    chk("R1", "reset result", int'(result), 0);
    chk("R1", "reset writeEn", int'(writeEn), 0);
    chk("R1", "reset busy", int'(busy), 0);
    rst_n = 1'b1;
    started = 1;
    // R5 add family, shift and rotate left
    issue(1, 8'h0F, 8'h01, 0, 0, "R5");
    issue(1, 8'h7F, 8'h01, 0, 0, "R5");
    issue(1, 8'hFF, 8'h01, 0, 0, "R5");
    issue(1, 8'h81, 8'h81, 0, 0, "R5");
    issue(2, 8'hC3, 8'hC3, 0, 0, "R5");
    issue(2, 8'h10, 8'h20, 0, 0, "R5");
    // R6 subtract borrow and half borrow
    issue(3, 8'h10, 8'h01, 0, 0, "R6");
    issue(3, 8'h80, 8'h01, 0, 0, "R6");
    issue(3, 8'h00, 8'h01, 0, 0, "R6");
    // R3 sticky zero chain
    issue(4, 8'h01, 8'h00, 0, 0, "R3");
    issue(5, 8'h05, 8'h05, 0, 0, "R4");
    issue(6, 8'h00, 8'h00, 0, 0, "R3");
    issue(6, 8'h03, 8'h00, 0, 0, "R3");
    issue(6, 8'h00, 8'h00, 0, 0, "R3");
    issue(4, 8'h20, 8'h20, 0, 0, "R3");
    // R2 increment and decrement with C set
    issue(18, 0, 0, 0, 1, "R10");
    issue(10, 8'h7F, 0, 0, 0, "R2");
    issue(11, 8'h80, 0, 0, 0, "R2");
    issue(11, 8'h00, 0, 0, 0, "R2");
    issue(10, 8'hFF, 0, 0, 0, "R2");
    // R7 logic
    issue(7, 8'hF0, 8'h3C, 0, 0, "R7");
    issue(8, 8'h00, 8'h00, 0, 0, "R7");
    issue(9, 8'hAA, 8'h55, 0, 0, "R7");
    // R8 unary
    issue(12, 8'h00, 0, 0, 0, "R8");
    issue(13, 8'h80, 0, 0, 0, "R8");
    issue(13, 8'h00, 0, 0, 0, "R8");
    issue(13, 8'h01, 0, 0, 0, "R8");
    issue(14, 8'h1E, 0, 0, 0, "R8");
    // R9 right shifts
    issue(15, 8'h81, 0, 0, 0, "R9");
    issue(16, 8'h81, 0, 0, 0, "R9");
    issue(17, 8'h02, 0, 0, 0, "R9");
    issue(17, 8'h01, 0, 0, 0, "R9");
    // R10 flag writes
    issue(18, 0, 0, 7, 1, "R10");
    issue(18, 0, 0, 6, 1, "R10");
    issue(18, 0, 0, 1, 0, "R10");
    issue(18, 0, 0, 7, 0, "R10");
    // R12 multiply
    issue(19, 8'hFF, 8'hFF, 0, 0, "R12");
    issue(19, 8'h00, 8'h05, 0, 0, "R12");
    issue(19, 8'h10, 8'h10, 0, 0, "R12");
    // R11 idle and unused codes change nothing
    issue(0, 8'h12, 8'h34, 0, 0, "R11");
    issue(25, 8'h12, 8'h34, 0, 0, "R11");
    idle(2);
    // R11 random mix
    for (int i = 0; i < 500; i++) begin
      int op;
      op = int'($urandom_range(31, 0));
      issue(op, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
            int'($urandom_range(7, 0)), int'($urandom_range(1, 0)), "R11");
    end
    idle(3);
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    finishRun();
  end
endmodule